// File: doc/BRIEF.md
# Isochronous Split Transaction Sequencer

This block moves a single isochronous split-transaction descriptor through the micro-frames of a frame. Software, or a descriptor fetch unit, loads the descriptor's Active and split-state bits. On every micro-frame tick the block compares the micro-frame index with a start-split mask or a complete-split mask. The split state picks which mask applies. When the bit for that index is set, the block sends one request to a transaction engine, and the request says which kind of split it is.

The engine returns one response code per request. From that code the block records progress: the split state moves from start to complete, a progress bit is set for each finished complete-split, or an error flag is raised and the descriptor retires. The updated descriptor status byte and the progress mask are outputs, so a write-back unit can store them.

Top module: `isoc_split_seq`

## Requirements
- R1: A synchronous active-high `rst` clears the status byte, the progress mask, the pending-request flag and `req_valid`.
- R2: A `load` pulse copies `status_in[7]` (Active) and `status_in[1]` (split state). It clears status bits 6..2 and the progress mask, and drops any pending request. Ticks and responses in the load cycle have no effect.
- R3: When Active=1 and split state=0, a tick whose index has its bit set in `s_mask` raises `req_valid` for exactly the next cycle, with `req_complete`=0 and `req_uframe` equal to that index.
- R4: When Active=1 and split state=1, a tick whose index has its bit set in `c_mask` raises `req_valid` for the next cycle, with `req_complete`=1.
- R5: No request follows a tick when Active=0 or when the selected mask bit is clear.
- R6: A success response to a start-split sets the split state (status bit 1) to 1. Codes 0, 5, 6 and 7 are success.
- R7: A success response to a complete-split sets the progress bit for its micro-frame. If `c_mask` has no set bit above that micro-frame, Active is cleared.
- R8: Code 1 sets status bit 6, code 3 sets bit 4 and code 4 sets bit 5. Each of these clears Active. Whenever any of bits 6..2 is set, Active is 0.
- R9: Code 2 sets status bit 3 and clears Active only when `is_in`=1. When `is_in`=0, code 2 is handled as success.
- R10: A tick that arrives while a response is pending, when the split state is 1 (after any same-cycle response) and the `c_mask` bit for that tick's index is set, sets status bit 2 and clears Active.
- R11: At most one request is outstanding. A tick that arrives while a response is pending issues no request. A response that arrives with nothing pending is ignored.
- R12: Status bit 0 always reads 0, and status bit 1 always shows the split state.
- R13: A response to a descriptor that has already retired only clears the pending flag. Status and progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start a new descriptor from `status_in` |
| status_in | input | 8 | Initial status byte (bits 7 and 1 used) |
| is_in | input | 1 | Transfer direction: 1 = IN |
| uframe_tick | input | 1 | One-cycle micro-frame strobe |
| uframe_idx | input | UF_W | Current micro-frame index |
| s_mask | input | 2**UF_W | Start-split micro-frame mask |
| c_mask | input | 2**UF_W | Complete-split micro-frame mask |
| req_valid | output | 1 | One-cycle request strobe to the transaction engine |
| req_complete | output | 1 | 0 = start-split, 1 = complete-split |
| req_uframe | output | UF_W | Micro-frame the request belongs to |
| rsp_valid | input | 1 | Response strobe from the engine |
| rsp_code | input | 3 | Response code (see R6 to R9) |
| status_out | output | 8 | Updated descriptor status byte |
| cprog_out | output | 2**UF_W | Complete-split progress mask |

## Verification
The assertions check several properties on every cycle:
- Bit 0 stays zero.
- A set error flag always goes with Active cleared.
- A request always follows a tick and matches the mask chosen by its split kind.
- Requests never come on two cycles in a row, and none follows an inactive state.
- Progress bits are never cleared except by a load.

The bench scenarios are needed for the outcomes that depend on a sequence of events:
- retirement on the last complete-split,
- the direction-dependent handling of code 2,
- the hold-off that marks a missed micro-frame,
- responses that arrive after retirement or with nothing pending.

// File: rtl/isoc_split_seq.sv
module isoc_split_seq #(
  parameter int UF_W = 3,
  localparam int NUF = 1 << UF_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [7:0]      status_in,
  input  logic            is_in,
  input  logic            uframe_tick,
  input  logic [UF_W-1:0] uframe_idx,
  input  logic [NUF-1:0]  s_mask,
  input  logic [NUF-1:0]  c_mask,
  output logic            req_valid,
  output logic            req_complete,
  output logic [UF_W-1:0] req_uframe,
  input  logic            rsp_valid,
  input  logic [2:0]      rsp_code,
  output logic [7:0]      status_out,
  output logic [NUF-1:0]  cprog_out
);
  localparam logic [2:0] C_ERR = 3'd1, C_XACT = 3'd2, C_BAB = 3'd3, C_DBUF = 3'd4;

  logic            act, st, f_err, f_dbuf, f_bab, f_xact, f_miss, pend, rv, rc;
  logic [UF_W-1:0] cur;
  logic [NUF-1:0]  cp;

  logic            n_act, n_st, n_err, n_dbuf, n_bab, n_xact, n_miss, n_pend, n_rv, n_rc;
  logic [UF_W-1:0] n_cur;
  logic [NUF-1:0]  n_cp;
  logic [NUF-1:0]  above;
  logic            last_cs;

  assign above   = (c_mask >> cur) >> 1;
  assign last_cs = (above == '0);

  always_comb begin
    n_act = act;  n_st = st;  n_err = f_err;  n_dbuf = f_dbuf;  n_bab = f_bab;
    n_xact = f_xact;  n_miss = f_miss;  n_pend = pend;  n_cur = cur;  n_cp = cp;
    n_rv = 1'b0;  n_rc = rc;
    if (rsp_valid && pend) begin
      n_pend = 1'b0;
      if (act) begin
        if (rsp_code == C_ERR) begin
          n_err = 1'b1;  n_act = 1'b0;
        end else if (rsp_code == C_BAB) begin
          n_bab = 1'b1;  n_act = 1'b0;
        end else if (rsp_code == C_DBUF) begin
          n_dbuf = 1'b1;  n_act = 1'b0;
        end else if (rsp_code == C_XACT && is_in) begin
          n_xact = 1'b1;  n_act = 1'b0;
        end else if (!st) begin
          n_st = 1'b1;
        end else begin
          n_cp[cur] = 1'b1;
          if (last_cs) n_act = 1'b0;
        end
      end
    end
    if (uframe_tick) begin
      if (pend) begin
        if (n_act && n_st && c_mask[uframe_idx]) begin
          n_miss = 1'b1;  n_act = 1'b0;
        end
      end else if (n_act && (n_st ? c_mask[uframe_idx] : s_mask[uframe_idx])) begin
        n_pend = 1'b1;  n_rv = 1'b1;  n_rc = n_st;  n_cur = uframe_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      act <= load ? status_in[7] : 1'b0;
      st  <= load ? status_in[1] : 1'b0;
      {f_err, f_dbuf, f_bab, f_xact, f_miss} <= '0;
      pend <= 1'b0;  rv <= 1'b0;  rc <= 1'b0;  cur <= '0;  cp <= '0;
    end else begin
      act <= n_act;  st <= n_st;  f_err <= n_err;  f_dbuf <= n_dbuf;  f_bab <= n_bab;
      f_xact <= n_xact;  f_miss <= n_miss;  pend <= n_pend;  rv <= n_rv;  rc <= n_rc;
      cur <= n_cur;  cp <= n_cp;
    end
  end

  assign req_valid    = rv;
  assign req_complete = rc;
  assign req_uframe   = cur;
  assign status_out   = {act, f_err, f_dbuf, f_bab, f_xact, f_miss, st, 1'b0};
  assign cprog_out    = cp;
endmodule

// File: rtl/isoc_split_seq_chk.sv
module isoc_split_seq_chk #(
  parameter int UF_W = 3,
  localparam int NUF = 1 << UF_W
) (
  input logic            clk,
  input logic            rst,
  input logic            load,
  input logic            uframe_tick,
  input logic [UF_W-1:0] uframe_idx,
  input logic [NUF-1:0]  s_mask,
  input logic [NUF-1:0]  c_mask,
  input logic            req_valid,
  input logic            req_complete,
  input logic [7:0]      status_out,
  input logic [NUF-1:0]  cprog_out
);
  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    status_out[0] == 1'b0);

  a_r8_error_retires: assert property (@(posedge clk) disable iff (rst)
    (|status_out[6:2]) |-> !status_out[7]);

  a_r5_inactive_no_req: assert property (@(posedge clk) disable iff (rst)
    (!status_out[7] && !load) |=> !req_valid);

  a_r11_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  a_r3_req_after_tick: assert property (@(posedge clk) disable iff (rst)
    (!rst && !load) ##1 req_valid |-> $past(uframe_tick));

  a_r3_start_gated: assert property (@(posedge clk) disable iff (rst)
    (!rst && !load) ##1 (req_valid && !req_complete) |-> $past(s_mask[uframe_idx]));

  a_r4_complete_gated: assert property (@(posedge clk) disable iff (rst)
    (!rst && !load) ##1 (req_valid && req_complete) |-> $past(c_mask[uframe_idx]));

  a_r7_progress_grows: assert property (@(posedge clk) disable iff (rst)
    (!load && !rst) |=> ((cprog_out & $past(cprog_out)) == $past(cprog_out)));
endmodule

bind isoc_split_seq isoc_split_seq_chk #(.UF_W(UF_W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .uframe_tick(uframe_tick),
  .uframe_idx(uframe_idx), .s_mask(s_mask), .c_mask(c_mask),
  .req_valid(req_valid), .req_complete(req_complete),
  .status_out(status_out), .cprog_out(cprog_out)
);

// File: tb/isoc_split_seq_tb.sv
module isoc_split_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1, load = 1'b0, is_in = 1'b1, uframe_tick = 1'b0;
  logic       rsp_valid = 1'b0;
  logic [2:0] rsp_code = 3'd0, uframe_idx = 3'd0, req_uframe;
  logic [7:0] status_in = 8'h00, s_mask = 8'h02, c_mask = 8'h1C;
  logic [7:0] status_out, cprog_out;
  logic       req_valid, req_complete;

  always #10 clk = ~clk;

  isoc_split_seq u_dut (
    .clk(clk), .rst(rst), .load(load), .status_in(status_in), .is_in(is_in),
    .uframe_tick(uframe_tick), .uframe_idx(uframe_idx), .s_mask(s_mask),
    .c_mask(c_mask), .req_valid(req_valid), .req_complete(req_complete),
    .req_uframe(req_uframe), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .status_out(status_out), .cprog_out(cprog_out)
  );

  int n_cmp = 0, n_bad = 0, cycles = 0;

  bit       m_act, m_st, m_pend, m_req, m_rc;
  bit [7:0] m_flags, m_cp;
  int       m_uf;

  always @(posedge clk) begin
    bit old_pend, need, more;
    if (rst || load) begin
      m_act = load && status_in[7];  m_st = load && status_in[1];
      m_flags = 0;  m_cp = 0;  m_pend = 0;  m_req = 0;  m_rc = 0;  m_uf = 0;
    end else begin
      m_req = 0;
      old_pend = m_pend;
      if (rsp_valid && m_pend) begin
        m_pend = 0;
        if (m_act) begin
          case (rsp_code)
            3'd1: begin m_flags[6] = 1; m_act = 0; end
            3'd3: begin m_flags[4] = 1; m_act = 0; end
            3'd4: begin m_flags[5] = 1; m_act = 0; end
            default:
              if (rsp_code == 3'd2 && is_in) begin m_flags[3] = 1; m_act = 0; end
              else if (!m_st) m_st = 1;
              else begin
                m_cp[m_uf] = 1;
                more = 0;
                for (int k = m_uf + 1; k < 8; k++) if (c_mask[k]) more = 1;
                if (!more) m_act = 0;
              end
          endcase
        end
      end
      if (uframe_tick) begin
        need = m_st ? c_mask[uframe_idx] : s_mask[uframe_idx];
        if (old_pend) begin
          if (m_act && m_st && need) begin m_flags[2] = 1; m_act = 0; end
        end else if (m_act && need) begin
          m_pend = 1; m_req = 1; m_rc = m_st; m_uf = int'(uframe_idx);
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [7:0] exp_st;
    cycles++;
    exp_st = {m_act, m_flags[6:2], m_st, 1'b0};
    n_cmp++;
    if (status_out !== exp_st || cprog_out !== m_cp || req_valid !== m_req ||
        (m_req && (req_complete !== m_rc || req_uframe !== 3'(m_uf)))) begin
      n_bad++;
      $display("FAIL R7 model cycle %0d: status %h cprog %h req %b/%b/%0d, expected %h %h %b/%b/%0d",
               cycles, status_out, cprog_out, req_valid, req_complete, req_uframe,
               exp_st, m_cp, m_req, m_rc, m_uf);
    end
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_load(logic [7:0] v);
    @(negedge clk); load = 1'b1; status_in = v;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic tick(logic [2:0] i);
    @(negedge clk); uframe_tick = 1'b1; uframe_idx = i;
    @(negedge clk); uframe_tick = 1'b0;
  endtask

  task automatic respond(logic [2:0] c);
    @(negedge clk); rsp_valid = 1'b1; rsp_code = c;
    @(negedge clk); rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 status after reset", status_out, 8'h00);
    chk("R1 cprog after reset", cprog_out, 8'h00);
    chk("R1 req after reset", {7'd0, req_valid}, 8'h00);

    do_load(8'hFF);
    chk("R2 load keeps only bits 7,1", status_out, 8'h82);
    chk("R12 bit0 zero", {7'd0, status_out[0]}, 8'h00);

    do_load(8'h80);
    tick(3'd0);
    chk("R5 no req on clear s_mask bit", {7'd0, req_valid}, 8'h00);
    tick(3'd1);
    chk("R3 start req", {5'd0, req_valid, req_complete, 1'b0}, 8'h04);
    chk("R3 start uframe", {5'd0, req_uframe}, 8'h01);
    respond(3'd0);
    chk("R6 state to complete", status_out, 8'h82);
    tick(3'd2);
    chk("R4 complete req", {6'd0, req_valid, req_complete}, 8'h03);
    respond(3'd0);
    chk("R7 progress bit2", cprog_out, 8'h04);
    chk("R7 still active", status_out, 8'h82);
    tick(3'd3); respond(3'd0);
    tick(3'd4); respond(3'd0);
    chk("R7 last retires", status_out, 8'h02);
    chk("R7 progress full", cprog_out, 8'h1C);
    tick(3'd5);
    chk("R5 inactive no req", {7'd0, req_valid}, 8'h00);
    respond(3'd1);
    chk("R11 unsolicited rsp ignored", status_out, 8'h02);

    do_load(8'h82); tick(3'd2); respond(3'd1);
    chk("R8 companion error", status_out, 8'h42);
    do_load(8'h82); tick(3'd2); respond(3'd3);
    chk("R8 babble", status_out, 8'h12);
    do_load(8'h82); tick(3'd2); respond(3'd4);
    chk("R8 buffer error", status_out, 8'h22);

    is_in = 1'b1;
    do_load(8'h82); tick(3'd2); respond(3'd2);
    chk("R9 IN no response", status_out, 8'h0A);
    is_in = 1'b0;
    do_load(8'h82); tick(3'd2); respond(3'd2);
    chk("R9 OUT code2 success status", status_out, 8'h82);
    chk("R9 OUT code2 success progress", cprog_out, 8'h04);
    is_in = 1'b1;

    do_load(8'h82); tick(3'd2); tick(3'd3);
    chk("R10 missed micro-frame", status_out, 8'h06);
    respond(3'd0);
    chk("R13 late rsp status", status_out, 8'h06);
    chk("R13 late rsp progress", cprog_out, 8'h00);

    do_load(8'h82); tick(3'd2); tick(3'd6);
    chk("R11 no second req", {7'd0, req_valid}, 8'h00);
    chk("R11 no hold-off on clear bit", status_out, 8'h82);
    respond(3'd0);
    chk("R11 pending rsp accepted", cprog_out, 8'h04);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset clears", {status_out | cprog_out}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule